// File: doc/BRIEF.md
# Unified Add/Subtract Datapath

This block is a purely combinational 64-bit adder. One equation serves every add and subtract variant an integer pipeline needs, including the carrying, extended and minus-one forms: sum = (I xor A) + B + C. Three small controls shape that one equation:

- **I** is all zeros or all ones. It comes from a single invert flag.
- **B** is the register operand, the constant 0 or the constant all-ones (-1).
- **C** is 0, 1, or a stored carry flag supplied as an input.

Subtract-from (B - A) is invert A, register B, carry-in 1. Add-to-zero extended is B = 0 with C taken from the carry flag. The minus-one extended forms use B = -1 with C taken from the carry flag.

The block has no storage and no handshake. Results follow the inputs within the same evaluation, so the surrounding execute stage registers them as it sees fit. Two carry-outs are provided: one from bit 63 for 64-bit operations, and one from bit 31 for 32-bit operations. Overflow detection and flag writeback belong to the caller.

Top module: `unified_addsub`

## Requirements
- R1: `sum` equals (A', B', C) added modulo 2^64, where A' is `op_a` inverted when `inv_a`=1 and unchanged when `inv_a`=0. B' and C are selected as in R3 and R4.
- R2: With `inv_a`=1, `b_sel`=0 and `c_sel`=1, `sum` equals `op_b` - `op_a` modulo 2^64. `co64` is 1 exactly when no borrow occurs, that is when `op_b` >= `op_a` unsigned.
- R3: `b_sel` picks B'. Code 0 selects `op_b`, code 1 selects zero, code 2 selects all ones, and code 3 behaves as code 0. With codes 1 and 2, `op_b` has no effect on any output.
- R4: `c_sel` picks C. Code 0 selects 0, code 1 selects 1, code 2 selects `ca_in`, and code 3 behaves as code 0. `ca_in` has no effect on any output unless `c_sel`=2.
- R5: `co64` is the carry out of bit 63 of the sum in R1.
- R6: `co32` is the carry out of bit 31 of the same addition. It depends on bits 31..0 of A' and B' and on C, and is independent of `co64`.
- R7: Minus-one extended forms: with `b_sel`=2 and `c_sel`=2, `sum` equals A' - 1 + `ca_in`. For A' = 0 this gives all ones with both carries 0 when `ca_in`=0, and zero with both carries 1 when `ca_in`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Register operand B |
| inv_a | input | 1 | Invert A before the add |
| b_sel | input | 2 | B source: 0 register, 1 zero, 2 all ones, 3 register |
| c_sel | input | 2 | Carry-in source: 0 zero, 1 one, 2 carry flag, 3 zero |
| ca_in | input | 1 | Stored carry flag |
| sum | output | 64 | Result |
| co64 | output | 1 | Carry out of bit 63 |
| co32 | output | 1 | Carry out of bit 31 |

## Verification
Plain adds with small operands confirm the basic equation. Operand pairs that carry out of bit 31 but not bit 63, and the reverse, tell the two carry outputs apart. Subtract-from is tried both with and without a borrow, which separates the inverted-A path and its carry sense from plain addition. Each B and carry-in code, including the two spare codes, is driven with a distracting `op_b` or `ca_in` value that would change the result if leaked, and the minus-one forms are tried with the carry flag both clear and set. A pseudo-random sweep over all select combinations then compares against a 65-bit reference add computed in the bench.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    BSRC_REG   = 2'd0,
    BSRC_ZERO  = 2'd1,
    BSRC_ONES  = 2'd2,
    BSRC_SPARE = 2'd3
  } bsrc_e;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_FLAG  = 2'd2,
    CIN_SPARE = 2'd3
  } cin_e;

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_raw,
  input  logic [WIDTH-1:0] b_raw,
  input  logic             invert,
  input  logic [1:0]       bsrc,
  output logic [WIDTH-1:0] a_eff,
  output logic [WIDTH-1:0] b_eff
);

  // I is a replicated invert flag, so A' = A xor I.
  logic [WIDTH-1:0] inv_mask;
  assign inv_mask = {WIDTH{invert}};
  assign a_eff    = a_raw ^ inv_mask;

  always_comb begin
    unique case (bsrc_e'(bsrc))
      BSRC_ZERO: b_eff = '0;
      BSRC_ONES: b_eff = '1;
      default:   b_eff = b_raw;
    endcase
  end

endmodule

// File: rtl/addsub_carry_mux.sv
module addsub_carry_mux
  import addsub_pkg::*;
(
  input  logic [1:0] csel,
  input  logic       flag,
  output logic       cin
);

  always_comb begin
    unique case (cin_e'(csel))
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = flag;
      default:  cin = 1'b0;
    endcase
  end

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int WIDTH = 64,
  parameter int SEG_W = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH/SEG_W-1:0] seg_co
);

  localparam int NSEG = WIDTH / SEG_W;

  logic [NSEG:0] chain;
  assign chain[0] = cin;

  // Segmented ripple: each segment's carry out is exposed as a tap.
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W:0] seg_res;
    assign seg_res = {1'b0, a[s*SEG_W +: SEG_W]}
                   + {1'b0, b[s*SEG_W +: SEG_W]}
                   + {{SEG_W{1'b0}}, chain[s]};
    assign sum[s*SEG_W +: SEG_W] = seg_res[SEG_W-1:0];
    assign chain[s+1]            = seg_res[SEG_W];
    assign seg_co[s]             = seg_res[SEG_W];
  end

  // Compare the segmented chain against a single wide addition.
  logic [WIDTH:0] flat_ref;
  always_comb begin
    flat_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    AST_SEGMENT_CHAIN: assert ({chain[NSEG], sum} == flat_ref) else $error("segment chain mismatch"); // R1
  end

endmodule

// File: rtl/unified_addsub.sv
module unified_addsub
  import addsub_pkg::*;
#(
  parameter int WIDTH    = 64,
  parameter int NARROW_W = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             inv_a,
  input  logic [1:0]       b_sel,
  input  logic [1:0]       c_sel,
  input  logic             ca_in,
  output logic [WIDTH-1:0] sum,
  output logic             co64,
  output logic             co32
);

  localparam int NSEG = WIDTH / NARROW_W;

  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [NSEG-1:0]  seg_co;

  addsub_operand_prep #(.WIDTH(WIDTH)) prep_i (
    .a_raw  (op_a),
    .b_raw  (op_b),
    .invert (inv_a),
    .bsrc   (b_sel),
    .a_eff  (a_eff),
    .b_eff  (b_eff)
  );

  addsub_carry_mux cmux_i (
    .csel (c_sel),
    .flag (ca_in),
    .cin  (cin)
  );

  addsub_core #(.WIDTH(WIDTH), .SEG_W(NARROW_W)) core_i (
    .a      (a_eff),
    .b      (b_eff),
    .cin    (cin),
    .sum    (sum),
    .seg_co (seg_co)
  );

  assign co64 = seg_co[NSEG-1];
  assign co32 = seg_co[0];

  logic [NARROW_W:0] low_ref;
  always_comb begin
    low_ref = {1'b0, a_eff[NARROW_W-1:0]} + {1'b0, b_eff[NARROW_W-1:0]}
            + {{NARROW_W{1'b0}}, cin};
    AST_A_INVERT:   assert (inv_a ? (a_eff == ~op_a) : (a_eff == op_a)) else $error("A inversion"); // R2
    AST_B_ZERO:     assert (b_sel != 2'd1 || b_eff == '0) else $error("B zero");                     // R3
    AST_B_ONES:     assert (b_sel != 2'd2 || b_eff == '1) else $error("B ones");                     // R3
    AST_B_REG:      assert (b_sel[0] != b_sel[1] || b_eff == op_b) else $error("B register");        // R3
    AST_CIN_SELECT: assert (cin == ((c_sel == 2'd1) || (c_sel == 2'd2 && ca_in))) else $error("cin"); // R4
    AST_NARROW_CO:  assert (co32 == low_ref[NARROW_W]) else $error("narrow carry");                  // R6
  end

endmodule

// File: tb/unified_addsub_tb.sv
module unified_addsub_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        inv;
    logic [1:0]  bs;
    logic [1:0]  cs;
    logic        ca;
    logic [63:0] s;
    logic        c64;
    logic        c32;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VECS [NVEC] = '{
    '{64'd5, 64'd7, 1'b0, 2'd0, 2'd0, 1'b0, 64'd12, 1'b0, 1'b0, 4'd1},                   // R1 plain add
    '{64'd3, 64'd10, 1'b1, 2'd0, 2'd1, 1'b0, 64'd7, 1'b1, 1'b1, 4'd2},                   // R2 subtract, no borrow
    '{64'd10, 64'd3, 1'b1, 2'd0, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFF9, 1'b0, 1'b0, 4'd2}, // R2 borrow
    '{64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 2'd0, 2'd0, 1'b0,
      64'h0000_0001_0000_0000, 1'b0, 1'b1, 4'd6},                                        // R6 low carry only
    '{ONES, 64'd1, 1'b0, 2'd0, 2'd0, 1'b0, 64'd0, 1'b1, 1'b1, 4'd5},                     // R5 full wrap
    '{64'h41, 64'hDEAD, 1'b0, 2'd1, 2'd2, 1'b1, 64'h42, 1'b0, 1'b0, 4'd3},               // R3 zero B, flag carry
    '{64'd0, 64'h1234, 1'b0, 2'd2, 2'd2, 1'b0, ONES, 1'b0, 1'b0, 4'd7},                  // R7 minus one, flag 0
    '{64'd0, 64'h1234, 1'b0, 2'd2, 2'd2, 1'b1, 64'd0, 1'b1, 1'b1, 4'd7},                 // R7 minus one, flag 1
    '{64'd5, 64'd0, 1'b1, 2'd2, 2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFA, 1'b1, 1'b1, 4'd7},  // R7 subtract-from minus one
    '{64'd1, 64'd1, 1'b0, 2'd0, 2'd3, 1'b1, 64'd2, 1'b0, 1'b0, 4'd4},                    // R4 spare code is zero
    '{64'd2, 64'd3, 1'b0, 2'd3, 2'd0, 1'b0, 64'd5, 1'b0, 1'b0, 4'd3},                    // R3 spare code is register
    '{64'd1, 64'd1, 1'b0, 2'd0, 2'd1, 1'b1, 64'd3, 1'b0, 1'b0, 4'd4},                    // R4 flag ignored on code 1
    '{64'h7FFF_FFFF, 64'h8000_0000, 1'b0, 2'd0, 2'd2, 1'b1,
      64'h0000_0001_0000_0000, 1'b0, 1'b1, 4'd6},                                        // R6 extended add into bit 32
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 2'd0, 2'd0, 1'b0,
      64'd0, 1'b1, 1'b0, 4'd5}                                                           // R5 high carry only
  };

  logic        clk = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        inv_a = 1'b0, ca_in = 1'b0;
  logic [1:0]  b_sel = '0, c_sel = '0;
  logic [63:0] sum;
  logic        co64, co32;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unified_addsub dut_i (
    .op_a(op_a), .op_b(op_b), .inv_a(inv_a), .b_sel(b_sel), .c_sel(c_sel),
    .ca_in(ca_in), .sum(sum), .co64(co64), .co32(co32)
  );

  task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic inv,
                       input logic [1:0] bs, input logic [1:0] cs, input logic ca);
    @(posedge clk);
    op_a = a; op_b = b; inv_a = inv; b_sel = bs; c_sel = cs; ca_in = ca;
    @(negedge clk);
  endtask

  // Reference from R1, R3, R4: 65-bit add; low-half add for the R6 carry.
  function automatic logic [65:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic inv, input logic [1:0] bs,
                                        input logic [1:0] cs, input logic ca);
    logic [63:0] ae, be;
    logic        c;
    logic [64:0] full;
    logic [32:0] low;
    ae = inv ? ~a : a;
    be = (bs == 2'd1) ? 64'd0 : (bs == 2'd2) ? ONES : b;
    c  = (cs == 2'd1) ? 1'b1 : (cs == 2'd2) ? ca : 1'b0;
    full = {1'b0, ae} + {1'b0, be} + {64'd0, c};
    low  = {1'b0, ae[31:0]} + {1'b0, be[31:0]} + {32'd0, c};
    return {full[64], low[32], full[63:0]};
  endfunction

  initial begin
    @(negedge clk);
    check("R1 idle zero inputs", {co64, co32, sum}, 66'd0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].inv, VECS[i].bs, VECS[i].cs, VECS[i].ca);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), {co64, co32, sum},
            {VECS[i].c64, VECS[i].c32, VECS[i].s});
    end

    // R3: op_b changes must not reach outputs when B is a constant.
    apply(64'h55, 64'h0, 1'b0, 2'd2, 2'd0, 1'b0);
    begin
      logic [65:0] first;
      first = {co64, co32, sum};
      apply(64'h55, ONES, 1'b0, 2'd2, 2'd0, 1'b0);
      check("R3 op_b ignored under all-ones B", {co64, co32, sum}, first);
    end

    // R4: ca_in must not reach outputs when c_sel is 0.
    apply(ONES, 64'd0, 1'b0, 2'd0, 2'd0, 1'b1);
    check("R4 flag ignored on code 0", {co64, co32, sum}, {2'b00, ONES});

    // R2: equal operands subtract to zero with no borrow.
    apply(64'hABCD, 64'hABCD, 1'b1, 2'd0, 2'd1, 1'b0);
    check("R2 equal operands", {co64, co32, sum}, {2'b11, 64'd0});

    // R1 sweep over all select combinations.
    begin
      logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
      logic [63:0] y = 64'hC2B2_AE3D_27D4_EB4F;
      for (int k = 0; k < 64; k++) begin
        x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
        y = y + x + 64'h1234_5678_9ABC_DEF1;
        apply(x, y, k[0], k[2:1], k[4:3], k[5]);
        check($sformatf("R1 sweep %0d", k), {co64, co32, sum},
              model(x, y, k[0], k[2:1], k[4:3], k[5]));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule